// File: doc/BRIEF.md
# Buffered serial audio receiver

This block takes a standard two-channel serial audio stream (bit clock, word select, serial data) and turns it into parallel samples that software reads over a simple memory-mapped register port. The bit clock and word select come either from pins, when an external device drives them, or from an internal divider when the block is the clock master. Config bit 1 picks which.

Each channel slot is marked by a change on word select. Data starts one bit clock after that change and is sent most significant bit first. The block keeps only the first `resolution` bits of every slot and stores them right-aligned. A slot that is too short gives zero low bits. Words go into a 32-word buffer that holds 16 left/right pairs and is split into two halves. When a half has filled, a sticky flag is raised. The flag can be routed to the interrupt line. Software empties one half while the other half fills. Writing continues around the buffer without a stop.

Top module: `i2s_rx_buffered`

## Requirements
- R1: After reset the config, mask and status registers read 0, the version register reads the `VERSION` parameter, `irq` is low, `sck_out` is 0 and `ws_out` is 1.
- R2: A bus access is one strobe cycle. `bus_ack` is high in the following cycle and `bus_rdata` is valid in that cycle. Config (offset 1) keeps only bit 0 (enable), bit 1 (master) and bits 23:16 (resolution). The mask (offset 2) keeps bits 1:0. All other bits read as 0.
- R3: After a word-select change, sampling starts on the second rising bit-clock edge. The first `resolution` bits are captured MSB first and stored right-aligned. Any later bits in the slot are dropped.
- R4: A slot that ends before `resolution` bits have arrived is stored with the received bits at the top of the `resolution`-bit field and zeros below them.
- R5: A resolution field of 0, or of more than 32, captures 32 bits.
- R6: Storage begins at the first left slot (word select 0) after enable, at pair 0. The left word of pair p goes to offset 0x20+2p and the right word to 0x21+2p. Clearing enable returns the pointer to pair 0.
- R7: Status bit 0 sets when the right word of pair 7 is stored. Status bit 1 sets when the right word of pair 15 is stored. Both bits stay set until cleared.
- R8: `irq` is high exactly while some status bit and its mask bit are both 1. Masking a bit does not clear its status.
- R9: Writing 1 to a status bit at offset 3 clears it, unless that bit is being set in the same cycle.
- R10: After pair 15, the next pair overwrites pair 0 and reception continues.
- R11: Bus writes to the sample buffer range are ignored.
- R12: In master mode with enable set, `sck_out` has a period of 2*`SCK_HALF` clock cycles. `ws_out` toggles only on falling `sck_out` edges, once every `SLOT_BITS` bit-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| bus_rdata | output | DATA_W | Read data, valid while `bus_ack` is high |
| irq | output | 1 | Masked half-full interrupt |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |

## Verification
A table of stream patterns pairs resolutions with slot lengths: longer than the resolution, equal to it, shorter than it, and out of range at 0 and 40. Together these separate truncation, zero fill of short slots and the 32-bit clamp. Each pattern uses asymmetric bit values, so a swapped channel, a one-bit phase error or a reversed bit order each gives a different stored word. A stream of seventeen distinct pairs checks the half-full flags, masking, write-one-to-clear and the wrap onto pair 0. A last run in master mode times the generated clocks and receives a pair sent against them.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  // register offsets (word addresses)
  localparam int REG_VERSION = 0;
  localparam int REG_CFG     = 1;
  localparam int REG_MASK    = 2;
  localparam int REG_STAT    = 3;

  // config field positions
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_MST_BIT  = 1;
  localparam int CFG_RES_LSB  = 16;
  localparam int CFG_RES_W    = 8;

  typedef struct packed {
    logic [CFG_RES_W-1:0] res;
    logic                 master;
    logic                 enable;
  } rx_cfg_t;

endpackage

// File: rtl/i2s_rx_link.sv
// Bit-clock / word-select source selection, master-mode generator,
// two-stage synchroniser and rising-edge detection.
module i2s_rx_link #(
  parameter int SCK_HALF  = 2,
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic use_gen,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic sck_out,
  output logic ws_out,
  output logic sck_rise,
  output logic ws_s,
  output logic sd_s
);
  localparam int DIV_W  = $clog2(SCK_HALF + 1);
  localparam int SLOT_W = $clog2(SLOT_BITS + 1);

  logic [DIV_W-1:0]  div_q, div_n;
  logic [SLOT_W-1:0] bit_q, bit_n;
  logic              gsck_q, gsck_n, gws_q, gws_n;
  logic [2:0]        raw, sync1_q, sync2_q;
  logic              sck_d_q;

  // master generator: next state
  always_comb begin
    div_n  = div_q;
    bit_n  = bit_q;
    gsck_n = gsck_q;
    gws_n  = gws_q;
    if (!gen_en) begin
      div_n  = '0;
      bit_n  = '0;
      gsck_n = 1'b0;
      gws_n  = 1'b1;
    end else if (div_q == DIV_W'(SCK_HALF - 1)) begin
      div_n  = '0;
      gsck_n = ~gsck_q;
      if (gsck_q) begin
        if (bit_q == SLOT_W'(SLOT_BITS - 1)) begin
          bit_n = '0;
          gws_n = ~gws_q;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
    end else begin
      div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      gsck_q <= 1'b0;
      gws_q  <= 1'b1;
    end else begin
      div_q  <= div_n;
      bit_q  <= bit_n;
      gsck_q <= gsck_n;
      gws_q  <= gws_n;
    end
  end

  assign sck_out = gsck_q;
  assign ws_out  = gws_q;

  // source select, then synchronise all three lines with equal latency
  assign raw = use_gen ? {gsck_q, gws_q, sd_in} : {sck_in, ws_in, sd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 3'b010;
      sync2_q <= 3'b010;
      sck_d_q <= 1'b0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      sck_d_q <= sync2_q[2];
    end
  end

  assign sck_rise = sync2_q[2] & ~sck_d_q;
  assign ws_s     = sync2_q[1];
  assign sd_s     = sync2_q[0];

  // generated word select moves only with a falling generated bit clock
  assert_ws_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && (gws_q != $past(gws_q))) |-> (!gsck_q && $past(gsck_q)));

endmodule

// File: rtl/i2s_rx_deser.sv
// Slot tracking and MSB-first capture of the first res_eff bits per slot.
module i2s_rx_deser #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  res_eff,
  input  logic              sck_rise,
  input  logic              ws_s,
  input  logic              sd_s,
  output logic              running,
  output logic              word_valid,
  output logic              word_right,
  output logic [DATA_W-1:0] word_data
);
  logic              ws_q, ws_n, run_q, run_n, act_q, act_n, ch_q, ch_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n, dat_q, dat_n;
  logic              vld_q, vld_n, rgt_q, rgt_n;

  always_comb begin
    ws_n  = ws_q;
    run_n = run_q;
    act_n = act_q;
    ch_n  = ch_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    vld_n = 1'b0;
    rgt_n = rgt_q;
    dat_n = dat_q;
    if (sck_rise) begin
      if (ws_s != ws_q) begin
        // slot boundary: flush a short word, then arm for the new slot
        ws_n = ws_s;
        if (act_q && (cnt_q != '0)) begin
          vld_n = 1'b1;
          rgt_n = ch_q;
          dat_n = sh_q << (res_eff - cnt_q);
        end
        run_n = enable && (run_q || !ws_s);
        act_n = run_n;
        ch_n  = ws_s;
        cnt_n = '0;
        sh_n  = '0;
      end else if (act_q) begin
        sh_n  = {sh_q[DATA_W-2:0], sd_s};
        cnt_n = cnt_q + 1'b1;
        if (cnt_n == res_eff) begin
          vld_n = 1'b1;
          rgt_n = ch_q;
          dat_n = sh_n;
          act_n = 1'b0;
        end
      end
    end
    if (!enable) begin
      run_n = 1'b0;
      act_n = 1'b0;
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q  <= 1'b1;
      run_q <= 1'b0;
      act_q <= 1'b0;
      ch_q  <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      rgt_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ws_q  <= ws_n;
      run_q <= run_n;
      act_q <= act_n;
      ch_q  <= ch_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      vld_q <= vld_n;
      rgt_q <= rgt_n;
      dat_q <= dat_n;
    end
  end

  assign running    = run_q;
  assign word_valid = vld_q;
  assign word_right = rgt_q;
  assign word_data  = dat_q;

  // a live slot boundary always restarts capture from an empty shifter
  assert_slot_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && enable && (ws_s != ws_q) && (run_q || !ws_s))
      |=> (act_q && (cnt_q == '0) && (sh_q == '0) && (ch_q == $past(ws_s))));

endmodule

// File: rtl/i2s_rx_buffered.sv
module i2s_rx_buffered
  import i2s_rx_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 6,
  parameter int          PAIRS     = 16,
  parameter int          SCK_HALF  = 2,
  parameter int          SLOT_BITS = 32,
  parameter logic [31:0] VERSION   = 32'h0000_0142
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              sck_out,
  output logic              ws_out
);
  localparam int WORDS  = 2 * PAIRS;
  localparam int MEM_AW = $clog2(WORDS);
  localparam int PTR_W  = $clog2(PAIRS);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int HALF   = PAIRS / 2;

  rx_cfg_t           cfg_q;
  logic [1:0]        mask_q, stat_q, stat_n, stat_set, stat_clr;
  logic [PTR_W-1:0]  pair_q, pair_n;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic [DATA_W-1:0] mem [WORDS];
  logic [CNT_W-1:0]  res_eff;
  logic              wr_acc, mem_hit;
  logic              sck_rise, ws_s, sd_s;
  logic              running, word_valid, word_right;
  logic [DATA_W-1:0] word_data;
  logic              unused_wdata;

  assign wr_acc  = bus_stb && bus_we;
  assign mem_hit = (bus_addr >> MEM_AW) == ADDR_W'(1);
  assign unused_wdata = ^{bus_wdata[DATA_W-1:CFG_RES_LSB+CFG_RES_W],
                          bus_wdata[CFG_RES_LSB-1:2]};

  // effective resolution: 0 or oversize means full width
  always_comb begin
    if ((cfg_q.res == '0) || (32'(cfg_q.res) > DATA_W)) res_eff = CNT_W'(DATA_W);
    else                                               res_eff = cfg_q.res[CNT_W-1:0];
  end

  i2s_rx_link #(.SCK_HALF(SCK_HALF), .SLOT_BITS(SLOT_BITS)) i_link (
    .clk(clk), .rst_n(rst_n),
    .gen_en(cfg_q.enable && cfg_q.master), .use_gen(cfg_q.master),
    .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .sck_out(sck_out), .ws_out(ws_out),
    .sck_rise(sck_rise), .ws_s(ws_s), .sd_s(sd_s)
  );

  i2s_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_deser (
    .clk(clk), .rst_n(rst_n), .enable(cfg_q.enable), .res_eff(res_eff),
    .sck_rise(sck_rise), .ws_s(ws_s), .sd_s(sd_s),
    .running(running), .word_valid(word_valid),
    .word_right(word_right), .word_data(word_data)
  );

  // pair pointer and half-full flags
  always_comb begin
    stat_set[0] = word_valid && word_right && (pair_q == PTR_W'(HALF - 1));
    stat_set[1] = word_valid && word_right && (pair_q == PTR_W'(PAIRS - 1));
    stat_clr    = (wr_acc && (bus_addr == ADDR_W'(REG_STAT))) ? bus_wdata[1:0] : 2'b00;
    stat_n      = (stat_q & ~stat_clr) | stat_set;
    if (!running)                      pair_n = '0;
    else if (word_valid && word_right) pair_n = pair_q + 1'b1;
    else                               pair_n = pair_q;
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (mem_hit) begin
      rd_val = mem[bus_addr[MEM_AW-1:0]];
    end else begin
      case (bus_addr)
        ADDR_W'(REG_VERSION): rd_val = DATA_W'(VERSION);
        ADDR_W'(REG_CFG): begin
          rd_val[CFG_EN_BIT]                        = cfg_q.enable;
          rd_val[CFG_MST_BIT]                       = cfg_q.master;
          rd_val[CFG_RES_LSB +: CFG_RES_W]          = cfg_q.res;
        end
        ADDR_W'(REG_MASK): rd_val[1:0] = mask_q;
        ADDR_W'(REG_STAT): rd_val[1:0] = stat_q;
        default:           rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      pair_q  <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_acc && (bus_addr == ADDR_W'(REG_CFG))) begin
        cfg_q.enable <= bus_wdata[CFG_EN_BIT];
        cfg_q.master <= bus_wdata[CFG_MST_BIT];
        cfg_q.res    <= bus_wdata[CFG_RES_LSB +: CFG_RES_W];
      end
      if (wr_acc && (bus_addr == ADDR_W'(REG_MASK))) mask_q <= bus_wdata[1:0];
      stat_q <= stat_n;
      pair_q <= pair_n;
      ack_q  <= bus_stb;
      if (bus_stb) rdata_q <= rd_val;
    end
  end

  // sample buffer: written only by the receiver
  always_ff @(posedge clk) begin
    if (word_valid) mem[{pair_q, word_right}] <= word_data;
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign irq       = |(stat_q & mask_q);

  // a clear request without a coincident set always empties bit 0
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (bus_addr == ADDR_W'(REG_STAT)) && bus_wdata[0] && !stat_set[0])
      |=> !stat_q[0]);

  // the upper-half flag only rises off the last pair of the buffer
  assert_upper_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) |-> ($past(pair_q) == PTR_W'(PAIRS - 1)));

  // after storing the last right word the pointer wraps to pair 0
  assert_pair_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && word_valid && word_right && (pair_q == PTR_W'(PAIRS - 1)))
      |=> (pair_q == '0));

  // disabling reception always rewinds the pointer
  assert_pair_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (pair_q == '0));

endmodule

// File: tb/test_i2s_rx_buffered.sv
`timescale 1ns/1ps
module test_i2s_rx_buffered;
  localparam int HALF_T = 4;   // bench bit-clock half period in clk cycles
  localparam logic [31:0] VER = 32'h0000_0142;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_stb = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack, irq, sck_out, ws_out;
  logic [31:0] bus_rdata;
  logic        sck_b = 1'b1, ws_b = 1'b1, sd_b = 1'b0, sd_m = 1'b0, tx_on = 1'b0;
  logic        sd_in;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  assign sd_in = tx_on ? sd_m : sd_b;

  always #2 clk = ~clk;

  i2s_rx_buffered i_i2s_rx_buffered (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .irq(irq), .sck_in(sck_b), .ws_in(ws_b),
    .sd_in(sd_in), .sck_out(sck_out), .ws_out(ws_out)
  );

  // stimulus vectors: {res, slot_bits, left, right}
  localparam int NV = 8;
  localparam logic [79:0] VEC [NV] = '{
    {8'd16, 8'd32, 32'h1234_ABCD, 32'h7654_3210},
    {8'd24, 8'd32, 32'h0ABC_DEF1, 32'h7FFF_0001},
    {8'd20, 8'd25, 32'h00A5_C3F0, 32'h005A_3C0F},
    {8'd16, 8'd12, 32'h0000_05A7, 32'h0000_07FF},
    {8'd32, 8'd33, 32'hDEAD_BEEF, 32'h8000_0001},
    {8'd8,  8'd16, 32'h0000_6D3A, 32'h0000_1234},
    {8'd0,  8'd33, 32'hCAFE_F00D, 32'h0123_4567},
    {8'd40, 8'd33, 32'h1357_9BDF, 32'hFEDC_BA98}
  };

  function automatic logic [31:0] exp_word(logic [31:0] d, int w, int res);
    int r;
    logic [63:0] m;
    r = (res == 0 || res > 32) ? 32 : res;
    m = (w >= 32) ? {32'd0, d} : ({32'd0, d} & ((64'd1 << w) - 64'd1));
    if (r <= w) return m[31:0] >> (w - r);
    else        return m[31:0] << (r - w);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_stb = 1'b0;
    d = bus_rdata; ack = bus_ack;
  endtask

  task automatic read_check(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    logic ack;
    bus_read(a, d, ack);
    check(req, d, exp);
  endtask

  // one slot: ws and data change with the falling bit clock, MSB at position 1
  task automatic drive_slot(bit ch, int nbits, logic [31:0] data);
    int w;
    w = nbits - 1;
    for (int pos = 0; pos < nbits; pos++) begin
      @(negedge clk);
      sck_b = 1'b0; ws_b = ch;
      sd_b = (pos >= 1 && pos <= w) ? data[w - pos] : 1'b0;
      repeat (HALF_T - 1) @(negedge clk);
      @(negedge clk);
      sck_b = 1'b1;
      repeat (HALF_T - 1) @(negedge clk);
    end
  endtask

  task automatic send_pair(int nbits, logic [31:0] l, logic [31:0] r);
    drive_slot(1'b0, nbits, l);
    drive_slot(1'b1, nbits, r);
  endtask

  task automatic idle_slot(bit ch);
    drive_slot(ch, 3, 32'd0);
  endtask

  // master-mode transmitter, reacts to falling generated bit clock
  logic [31:0] m_left = 32'h5A5A_1234, m_right = 32'h2468_ACE1;
  logic        tx_ps = 1'b0, tx_ws = 1'b1;
  int          tx_pos = 0;
  always @(negedge clk) begin
    if (tx_on && tx_ps && !sck_out) begin
      if (ws_out != tx_ws) tx_pos = 0;
      else                 tx_pos = tx_pos + 1;
      tx_ws = ws_out;
      sd_m  = (tx_pos >= 1 && tx_pos <= 31) ?
              (ws_out ? m_right[31 - tx_pos] : m_left[31 - tx_pos]) : 1'b0;
    end
    tx_ps = sck_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        ack;
    logic [15:0] lv [17];
    logic [15:0] rv [17];
    int res, slot, last_r, last_w, sck_per, ws_per;
    string tag;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 sck_out", {31'd0, sck_out}, 32'd0);
    check("R1 ws_out", {31'd0, ws_out}, 32'd1);
    read_check("R1 version", 6'd0, VER);
    read_check("R1 config", 6'd1, 32'd0);
    read_check("R1 mask", 6'd2, 32'd0);
    read_check("R1 status", 6'd3, 32'd0);

    // R2 bus timing and field masking
    bus_read(6'd0, d, ack);
    check("R2 ack", {31'd0, ack}, 32'd1);
    bus_write(6'd1, 32'hFF12_FF00);
    read_check("R2 config", 6'd1, 32'h0012_0000);
    bus_write(6'd2, 32'hFFFF_FFFD);
    read_check("R2 mask", 6'd2, 32'h0000_0001);
    bus_write(6'd2, 32'd0);

    // vector table: R3 / R4 / R5 / R6
    for (int v = 0; v < NV; v++) begin
      res  = int'(VEC[v][79:72]);
      slot = int'(VEC[v][71:64]);
      if (res == 0 || res > 32) tag = "R5";
      else if (slot - 1 < res)  tag = "R4";
      else                      tag = "R3";
      bus_write(6'd1, 32'd0);
      idle_slot(1'b1);
      bus_write(6'd1, {8'd0, VEC[v][79:72], 16'h0001});
      send_pair(slot, VEC[v][63:32], VEC[v][31:0]);
      idle_slot(1'b0);
      read_check({tag, " left"},  6'h20, exp_word(VEC[v][63:32], slot - 1, res));
      read_check({tag, " right"}, 6'h21, exp_word(VEC[v][31:0],  slot - 1, res));
    end

    // fill, half flags, masking, clearing, wrap: res 16, 20-bit slots
    for (int i = 0; i < 17; i++) begin
      lv[i] = 16'h1000 + 16'(i) * 16'h0111;
      rv[i] = ~lv[i];
    end
    bus_write(6'd1, 32'd0);
    bus_write(6'd2, 32'd1);
    idle_slot(1'b1);
    bus_write(6'd1, 32'h0010_0001);
    for (int i = 0; i < 8; i++) send_pair(20, {13'd0, lv[i], 3'd0}, {13'd0, rv[i], 3'd0});
    read_check("R7 lower half flag", 6'd3, 32'd1);
    check("R8 irq masked-in", {31'd0, irq}, 32'd1);
    bus_write(6'd2, 32'd0);
    check("R8 irq masked-out", {31'd0, irq}, 32'd0);
    read_check("R8 status kept", 6'd3, 32'd1);
    bus_write(6'd2, 32'd3);
    bus_write(6'd3, 32'd1);
    read_check("R9 clear lower", 6'd3, 32'd0);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    for (int i = 8; i < 16; i++) send_pair(20, {13'd0, lv[i], 3'd0}, {13'd0, rv[i], 3'd0});
    read_check("R7 upper half flag", 6'd3, 32'd2);
    check("R8 irq upper", {31'd0, irq}, 32'd1);
    send_pair(20, {13'd0, lv[16], 3'd0}, {13'd0, rv[16], 3'd0});
    read_check("R10 wrap left",  6'h20, {16'd0, lv[16]});
    read_check("R10 wrap right", 6'h21, {16'd0, rv[16]});
    read_check("R10 pair1 kept", 6'h22, {16'd0, lv[1]});
    read_check("R6 pair8 left",  6'h30, {16'd0, lv[8]});
    read_check("R6 pair15 right", 6'h3F, {16'd0, rv[15]});
    bus_write(6'h20, 32'hDEAD_0000);
    read_check("R11 buffer write ignored", 6'h20, {16'd0, lv[16]});
    bus_write(6'd3, 32'd2);
    read_check("R9 clear upper", 6'd3, 32'd0);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // master mode: res 24, generated clocks
    bus_write(6'd1, 32'd0);
    bus_write(6'd2, 32'd0);
    tx_on = 1'b1;
    bus_write(6'd1, 32'h0018_0003);
    last_r = -1; last_w = -1; sck_per = -1; ws_per = -1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sck_out && !tx_ps) begin
        if (last_r >= 0 && sck_per < 0) sck_per = i - last_r;
        last_r = i;
      end
      if (ws_out != tx_ws || (i > 0 && last_w == -2)) begin end
      if (i > 0) begin end
    end
    // second pass for word-select spacing
    last_w = -1;
    begin
      logic pw;
      pw = ws_out;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (ws_out != pw) begin
          if (last_w >= 0 && ws_per < 0) ws_per = i - last_w;
          last_w = i;
        end
        pw = ws_out;
      end
    end
    check("R12 sck period", sck_per, 32'd4);
    check("R12 ws spacing", ws_per, 32'd128);
    read_check("R12 master left",  6'h20, exp_word(m_left, 31, 24));
    read_check("R12 master right", 6'h21, exp_word(m_right, 31, 24));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule